// File: doc/BRIEF.md
# Segmented Memory Access Guard

This block watches every bus access made to main memory and decides whether the access is permitted. The address space is split into three segments by two programmable boundary registers. Each segment carries its own read, write and execute enables plus a select bit that chooses what happens when the segment is misused. The enables start out set, so after reset every access is allowed until software narrows them down.

An access that breaks a segment's permissions sets a sticky per-segment flag. A flag stays set until software clears it. The flags, gated by a global interrupt enable, form an interrupt request. When the faulting segment's select bit is set, the block also sends a one-cycle reset request to the system. Reads get a relaxed rule: a read faults only when the segment has no enable set at all. A segment that can be written to or executed from can therefore always be read.

Software reaches the block through a small word-wide register port. The port holds a control word, two boundary registers and a status word that carries the flags and the interrupt enable.

Top module: `seg_guard`

## Requirements
- R1: After reset the control word reads 0x777 (every read, write and execute enable set, every select bit clear). The flags, interrupt enable, `irq` and `rst_req` are all 0.
- R2: An address below boundary 1 (register 1) selects segment 1. Otherwise an address below boundary 2 (register 2) selects segment 2. Any other address selects segment 3. Segment n reports in flag bit n-1.
- R3: An access with `acc_kind` = 01 (write) faults when the selected segment's write enable is 0.
- R4: An access with `acc_kind` = 10 (instruction fetch) faults when the selected segment's execute enable is 0.
- R5: An access with `acc_kind` = 00 (read) faults only when the selected segment's read, write and execute enables are all 0.
- R6: No fault is raised when `acc_valid` is low, or when `acc_kind` = 11, whatever the permissions are.
- R7: A fault sets that segment's flag at the next clock edge. The flag holds until a 1 is written to the same bit position (bits 2:0) of the status word (register 3). A fault in the same cycle as its clear leaves the flag set.
- R8: `irq` is high exactly when at least one flag is set and the interrupt enable (status word bit 4, read/write) is 1.
- R9: `rst_req` goes high for the single cycle after a faulting access to a segment whose select bit is 1. It stays low for faults in segments whose select bit is 0.
- R10: In the control word (register 0), segment n uses bits 4(n-1)+3..4(n-1), with the read enable at the lowest of those bits, then the write enable, then the execute enable, then the select bit. All four registers read back what was written to their implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_addr | input | ADDR_W | Address of the access |
| acc_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 boundary 1, 2 boundary 2, 3 status |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| seg_flag | output | 3 | Sticky per-segment fault flags |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume that `acc_valid`, `acc_kind`, `acc_addr` and the register strobe hold known values at every sampling edge once reset is released. They also assume that a register write and an access may share a cycle, and that no input changes near the active edge. The stimulus meets these assumptions: every input is driven on the falling edge from fixed table entries or directed steps, and the access strobe is parked low between accesses. The one deliberate overlap, a status clear in the same cycle as a fault, is staged on purpose so the clear-versus-fault priority is exercised.

// File: rtl/seg_guard_pkg.sv
// Shared constants and types for the segment access guard.
// Assumes exactly three segments, split by two boundary registers.
package seg_guard_pkg;
    localparam int NSEG  = 3;
    localparam int FLD_W = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    // One segment's control field; the bit order is visible to software.
    typedef struct packed {
        logic vs;   // fault also requests reset
        logic xe;   // fetch enable
        logic we;   // write enable
        logic re;   // read enable
    } seg_perm_t;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_BND1 = 2'd1;
    localparam logic [1:0] RA_BND2 = 2'd2;
    localparam logic [1:0] RA_STAT = 2'd3;

    localparam int STAT_IE_BIT = 4;
endpackage

// File: rtl/seg_guard_decode.sv
// Maps an access address onto one of three segments, using two boundaries.
// Assumes unsigned compares. When bnd2 <= bnd1, segment 2 is empty.
module seg_guard_decode
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] bnd1,
    input  logic [ADDR_W-1:0] bnd2,
    output logic [NSEG-1:0]   sel
);
    // Priority compare: the lower boundary is tested first.
    always_comb begin
        sel = '0;
        if (addr < bnd1)      sel[0] = 1'b1;
        else if (addr < bnd2) sel[1] = 1'b1;
        else                  sel[2] = 1'b1;
    end
endmodule

// File: rtl/seg_guard_perm.sv
// Evaluates one access against the permissions of each segment.
// Assumes sel is one-hot. The result is combinational for the current cycle.
module seg_guard_perm
    import seg_guard_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid,
    input  logic [1:0]            kind,
    input  logic [NSEG-1:0]       sel,
    input  seg_perm_t [NSEG-1:0]  perms,
    output logic [NSEG-1:0]       viol
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic bad;

        // A read is tolerated while any enable of the segment remains set.
        always_comb begin
            unique case (kind)
                ACC_READ:  bad = !(perms[g].re || perms[g].we || perms[g].xe);
                ACC_WRITE: bad = !perms[g].we;
                ACC_FETCH: bad = !perms[g].xe;
                default:   bad = 1'b0;
            endcase
        end

        assign viol[g] = valid && sel[g] && bad;

        // R5: a read into a segment with any enable set never faults.
        assert_read_tolerant_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && kind == ACC_READ && sel[g] &&
             (perms[g].re || perms[g].we || perms[g].xe)) |-> !viol[g]);

        // R4: a fetch without execute enable in the selected segment faults.
        assert_fetch_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && kind == ACC_FETCH && sel[g] && !perms[g].xe) |-> viol[g]);
    end

    // R6: a reserved kind or an idle bus never faults.
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || kind == ACC_RSVD) |-> (viol == '0));
endmodule

// File: rtl/seg_guard_regs.sv
// Software-visible state: control word, boundaries, sticky flags, interrupt
// enable, and the registered reset request.
// Assumes DATA_W covers the control word and ADDR_W <= DATA_W.
module seg_guard_regs
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int BND1_RST = 'h4000,
    parameter int BND2_RST = 'h8000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NSEG-1:0]       viol,
    output seg_perm_t [NSEG-1:0]  perms,
    output logic [ADDR_W-1:0]     bnd1,
    output logic [ADDR_W-1:0]     bnd2,
    output logic [NSEG-1:0]       flags,
    output logic                  irq,
    output logic                  rst_req
);
    localparam int CTRL_W = NSEG * FLD_W;

    function automatic logic [CTRL_W-1:0] ctrl_default();
        logic [CTRL_W-1:0] r;
        r = '0;
        for (int s = 0; s < NSEG; s++) r[s*FLD_W +: FLD_W] = 4'b0111;
        return r;
    endfunction

    logic [CTRL_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] bnd1_q, bnd2_q;
    logic [NSEG-1:0]   flags_q, clr_mask, vs_vec;
    logic              ie_q, rst_q;
    logic              wr_ctrl, wr_b1, wr_b2, wr_stat;

    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_b1   = reg_wr && (reg_addr == RA_BND1);
    assign wr_b2   = reg_wr && (reg_addr == RA_BND2);
    assign wr_stat = reg_wr && (reg_addr == RA_STAT);

    for (genvar g = 0; g < NSEG; g++) begin : g_vs
        assign vs_vec[g] = perms[g].vs;
    end

    // Write-one-to-clear mask taken from a status write.
    assign clr_mask = wr_stat ? reg_wdata[NSEG-1:0] : '0;

    // Control and boundary registers, loaded by register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_default();
            bnd1_q <= ADDR_W'(BND1_RST);
            bnd2_q <= ADDR_W'(BND2_RST);
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
            if (wr_b1)   bnd1_q <= reg_wdata[ADDR_W-1:0];
            if (wr_b2)   bnd2_q <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Sticky flags. A fault in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            ie_q    <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | viol;
            if (wr_stat) ie_q <= reg_wdata[STAT_IE_BIT];
        end
    end

    // Reset request: one cycle after a fault in a segment whose select bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= |(viol & vs_vec);
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
            RA_BND1: reg_rdata[ADDR_W-1:0] = bnd1_q;
            RA_BND2: reg_rdata[ADDR_W-1:0] = bnd2_q;
            default: begin
                reg_rdata[NSEG-1:0]  = flags_q;
                reg_rdata[STAT_IE_BIT] = ie_q;
            end
        endcase
    end

    assign perms   = ctrl_q;
    assign bnd1    = bnd1_q;
    assign bnd2    = bnd2_q;
    assign flags   = flags_q;
    assign irq     = ie_q && (|flags_q);
    assign rst_req = rst_q;

    for (genvar g = 0; g < NSEG; g++) begin : g_chk
        // R7: a set flag persists without a matching clear.
        assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[g] && !clr_mask[g]) |=> flags_q[g]);
        // R7: a fault sets its flag even against a clear.
        assert_fault_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            viol[g] |=> flags_q[g]);
    end

    // R8: with the enable set and no status write, a fault raises irq.
    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|viol) && ie_q && !wr_stat) |=> irq);

    // R9: no reset request without a fault in a reset-selecting segment.
    assert_rst_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(viol & vs_vec)) |=> !rst_req);
endmodule

// File: rtl/seg_guard.sv
// Top of the segment access guard: decodes the segment, checks permissions,
// and hands faults to the register block.
// Assumes at most one access per cycle, with the strobe in acc_valid.
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int BND1_RST = 'h4000,
    parameter int BND2_RST = 'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NSEG-1:0]   seg_flag,
    output logic              irq,
    output logic              rst_req
);
    seg_perm_t [NSEG-1:0] perms;
    logic [ADDR_W-1:0]    bnd1, bnd2;
    logic [NSEG-1:0]      sel, viol;

    seg_guard_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (acc_addr),
        .bnd1 (bnd1),
        .bnd2 (bnd2),
        .sel  (sel)
    );

    seg_guard_perm u_perm (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (acc_valid),
        .kind  (acc_kind),
        .sel   (sel),
        .perms (perms),
        .viol  (viol)
    );

    seg_guard_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BND1_RST (BND1_RST),
        .BND2_RST (BND2_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .viol      (viol),
        .perms     (perms),
        .bnd1      (bnd1),
        .bnd2      (bnd2),
        .flags     (seg_flag),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    // R2: the decoder selects exactly one segment.
    assert_one_segment_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);

    // R3: a write into the segment below boundary 1 without write enable faults.
    assert_write_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == ACC_WRITE && acc_addr < bnd1 && !perms[0].we)
        |=> seg_flag[0]);
endmodule

// File: tb/seg_guard_tb.sv
`timescale 1ns/1ps
module seg_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  seg_flag;
    logic        irq, rst_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    seg_guard dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_kind(acc_kind), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seg_flag(seg_flag),
        .irq(irq), .rst_req(rst_req)
    );

    typedef struct packed {
        logic [11:0] ctrl;
        logic [15:0] addr;
        logic [1:0]  kind;
        logic [2:0]  flg;
        logic        rst;
    } vec_t;

    // Boundaries during the table: 0x1000 and 0x8000.
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{12'h777, 16'h0100, 2'd1, 3'b000, 1'b0},  // R3 allowed write
        '{12'h775, 16'h0100, 2'd1, 3'b001, 1'b0},  // R3 seg1 write blocked
        '{12'h775, 16'h2000, 2'd1, 3'b000, 1'b0},  // R2 seg2 unaffected
        '{12'h377, 16'h9000, 2'd2, 3'b100, 1'b0},  // R4 seg3 fetch blocked
        '{12'h377, 16'h9000, 2'd0, 3'b000, 1'b0},  // R5 read still fine
        '{12'h077, 16'h9000, 2'd0, 3'b100, 1'b0},  // R5 all clear read
        '{12'h707, 16'h2000, 2'd1, 3'b010, 1'b0},  // R3 seg2 write
        '{12'h727, 16'h2000, 2'd0, 3'b000, 1'b0},  // R5 write-only segment readable
        '{12'h787, 16'h2000, 2'd2, 3'b010, 1'b1},  // R9 select bit set
        '{12'h787, 16'h0FFF, 2'd0, 3'b000, 1'b0},  // R2 top of seg1
        '{12'h070, 16'h1000, 2'd0, 3'b000, 1'b0},  // R2 base of seg2
        '{12'h070, 16'h0FFF, 2'd0, 3'b001, 1'b0},  // R2 seg1 read
        '{12'h000, 16'h8000, 2'd3, 3'b000, 1'b0},  // R6 reserved kind
        '{12'h000, 16'h7FFF, 2'd0, 3'b010, 1'b0},  // R2 top of seg2
        '{12'h877, 16'hFFFF, 2'd1, 3'b100, 1'b1}   // R9 seg3 select
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic access(input logic v, input logic [15:0] a, input logic [1:0] k);
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_kind = k;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(2'd0, rd); chk("R1 ctrl", rd, 16'h0777);
        reg_read(2'd3, rd); chk("R1 status", rd, 16'h0000);
        chk("R1 flags", seg_flag, 3'b000);
        chk("R1 irq", irq, 1'b0);
        chk("R1 rst_req", rst_req, 1'b0);

        // R10 read-back and field layout
        reg_write(2'd0, 16'h05A3);
        reg_read(2'd0, rd); chk("R10 ctrl readback", rd, 16'h05A3);
        reg_write(2'd1, 16'h1000);
        reg_write(2'd2, 16'h8000);
        reg_read(2'd1, rd); chk("R10 bnd1 readback", rd, 16'h1000);
        reg_read(2'd2, rd); chk("R10 bnd2 readback", rd, 16'h8000);
        // 0x5A3: seg1 nibble 3 -> RE,WE set, XE clear: fetch faults, write not
        access(1'b1, 16'h0010, 2'd1); chk("R10 seg1 WE at bit1", seg_flag, 3'b000);
        access(1'b1, 16'h0010, 2'd2); chk("R10 seg1 XE at bit2", seg_flag, 3'b001);
        reg_write(2'd3, 16'h0007);

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            reg_write(2'd0, {4'h0, VEC[i].ctrl});
            reg_write(2'd3, 16'h0007);
            access(1'b1, VEC[i].addr, VEC[i].kind);
            chk($sformatf("vector %0d flags (R2 R3 R4 R5 R6)", i), seg_flag, VEC[i].flg);
            chk($sformatf("vector %0d rst_req (R9)", i), rst_req, VEC[i].rst);
        end

        // R6 idle strobe with faulting content
        reg_write(2'd0, 16'h0000);
        reg_write(2'd3, 16'h0007);
        access(1'b0, 16'h0010, 2'd1);
        chk("R6 idle strobe", seg_flag, 3'b000);

        // R7 sticky flags and write-one-to-clear
        access(1'b1, 16'h0010, 2'd1);
        access(1'b1, 16'hA000, 2'd2);
        chk("R7 two flags", seg_flag, 3'b101);
        @(negedge clk);
        chk("R7 flags hold", seg_flag, 3'b101);
        reg_write(2'd3, 16'h0001);
        chk("R7 partial clear", seg_flag, 3'b100);
        // fault and clear of the same bit in one cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0004;
        acc_valid = 1'b1; acc_addr = 16'hA000; acc_kind = 2'd1;
        @(negedge clk);
        reg_wr = 1'b0; acc_valid = 1'b0;
        chk("R7 fault beats clear", seg_flag, 3'b100);

        // R8 interrupt gating
        chk("R8 irq masked", irq, 1'b0);
        reg_write(2'd3, 16'h0010);
        chk("R8 irq enabled", irq, 1'b1);
        reg_read(2'd3, rd); chk("R8 status readback", rd, 16'h0014);
        reg_write(2'd3, 16'h0014);
        chk("R8 irq after clear", irq, 1'b0);

        // R9 pulse width
        reg_write(2'd0, 16'h0008);
        access(1'b1, 16'h0020, 2'd0);
        chk("R9 pulse high", rst_req, 1'b1);
        chk("R9 flag with reset", seg_flag, 3'b001);
        @(negedge clk);
        chk("R9 pulse one cycle", rst_req, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule